// File: doc/BRIEF.md
# Ethernet Speed and Duplex Resolver

This block decides which of four operating modes a 10/100 twisted-pair PHY runs in: 100 Mb/s full duplex, 100 Mb/s half duplex, 10 Mb/s full duplex or 10 Mb/s half duplex. In negotiated operation it takes the abilities this end advertises and the abilities the far end reported. When the negotiation-finished strobe arrives, it keeps the modes present in both words and picks the best one by a fixed ranking.

When negotiation is switched off in the control word, the speed and duplex control bits pick the mode directly. The result is a one-hot mode select, a flag that says the select is meaningful, and a flag that says the two ends share no usable mode. All three are registered, so they change one clock after the event that causes the change.

Top module: `an_mode_resolver`

## Requirements
- R1: A mode can be chosen by negotiation only when its ability bit is set in both the local word and the partner word.
- R2: Ability word bits are: bit 5 = 10 half, bit 6 = 10 full, bit 7 = 100 half, bit 8 = 100 full, bit 9 = the four-pair 100 mode. Among the common modes the ranking, best first, is 100 full, four-pair 100, 100 half, 10 full, 10 half.
- R3: The four-pair 100 mode is never selected. If it is the only common mode, the result is treated as having no common mode.
- R4: Partner and local ability words are sampled only on a cycle where the completion strobe is high. Changes to them at other times leave the outputs unchanged.
- R5: With control bit 12 clear, the outputs are set as follows. Control bit 13 picks 100 (1) or 10 (0) Mb/s. Control bit 8 picks full (1) or half (0) duplex. The valid flag is 1 and the no-common flag is 0.
- R6: With control bit 12 set, control bits 13 and 8 have no effect on any output.
- R7: A completion strobe with no supported common mode sets the no-common flag and the valid flag, and selects 10 half.
- R8: Outputs update on the clock edge that samples the strobe or the control change, and are seen one cycle after the input.
- R9: In the first cycle that has control bit 12 set after a cycle with it clear, the following happens unless the strobe is also high then: the valid flag clears, 10 half is selected, and the no-common flag is 0. This state holds until a strobe arrives. The reset state is the same.
- R10: The mode select is always one-hot: bit 3 = 100 full, bit 2 = 100 half, bit 1 = 10 full, bit 0 = 10 half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 16 | Control word (bit 12 negotiate, bit 13 speed, bit 8 duplex) |
| local_adv_i | input | 16 | Local advertised abilities |
| partner_abil_i | input | 16 | Partner reported abilities |
| an_done_i | input | 1 | Negotiation-complete strobe |
| mode_sel_o | output | 4 | One-hot resolved mode |
| resolved_o | output | 1 | Mode select is valid |
| no_common_o | output | 1 | No supported common mode |

## Verification
The assertions assume that the control word and ability words are stable or change only at clock edges. They also assume that the completion strobe is treated as a level sampled on each edge, so a strobe held high for several cycles re-resolves each cycle. The stimulus changes all inputs only at the falling clock edge. It sends both single-cycle strobes and back-to-back strobes, so the hold property is checked only on cycles that have no strobe.

// File: rtl/an_res_pkg.sv
package an_res_pkg;
   localparam int NUM_MODES = 4;
   localparam int MODE_IDX_W = 2;

   // index in the one-hot select, also the rank (higher wins)
   typedef enum logic [MODE_IDX_W-1:0] {
      MODE_10_HALF  = 2'd0,
      MODE_10_FULL  = 2'd1,
      MODE_100_HALF = 2'd2,
      MODE_100_FULL = 2'd3
   } mode_e;

   typedef struct packed {
      logic [NUM_MODES-1:0] sel;
      logic                 valid;
      logic                 none;
   } res_t;

   localparam logic [NUM_MODES-1:0] SEL_DEFAULT = 4'b0001;

   localparam res_t RES_IDLE = '{sel: SEL_DEFAULT, valid: 1'b0, none: 1'b0};
endpackage

// File: rtl/an_ability_match.sv
module an_ability_match #(
   parameter int ABIL_W  = 16,
   parameter int POS_10H = 5,
   parameter int POS_10F = 6,
   parameter int POS_TXH = 7,
   parameter int POS_TXF = 8
) (
   input  logic [ABIL_W-1:0]                local_i,
   input  logic [ABIL_W-1:0]                partner_i,
   output logic [an_res_pkg::NUM_MODES-1:0] cand_o
);
   import an_res_pkg::*;

   localparam int POS_TAB [NUM_MODES] = '{POS_10H, POS_10F, POS_TXH, POS_TXF};

   initial begin
      assert (POS_10H < ABIL_W && POS_10F < ABIL_W && POS_TXH < ABIL_W && POS_TXF < ABIL_W)
         else $fatal(1, "ability bit position beyond word width");
   end

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
      assign cand_o[m] = local_i[POS_TAB[m]] & partner_i[POS_TAB[m]];
   end
endmodule

// File: rtl/an_prio_pick.sv
module an_prio_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] pick_o,
   output logic         none_o
);
   initial begin
      assert (N >= 1) else $fatal(1, "priority picker needs at least one input");
   end

   logic [N:0] taken;
   assign taken[N] = 1'b0;

   // highest index wins
   for (genvar i = N - 1; i >= 0; i--) begin : g_rank
      assign pick_o[i] = req_i[i] & ~taken[i+1];
      assign taken[i]  = taken[i+1] | req_i[i];
   end

   assign none_o = ~taken[0];
endmodule

// File: rtl/an_forced_decode.sv
module an_forced_decode (
   input  logic                             speed_i,
   input  logic                             duplex_i,
   output logic [an_res_pkg::NUM_MODES-1:0] sel_o
);
   import an_res_pkg::*;

   logic [MODE_IDX_W-1:0] idx;
   assign idx = {speed_i, duplex_i};

   for (genvar m = 0; m < NUM_MODES; m++) begin : g_dec
      assign sel_o[m] = (idx == MODE_IDX_W'(m));
   end
endmodule

// File: rtl/an_mode_resolver.sv
module an_mode_resolver #(
   parameter int ABIL_W   = 16,
   parameter int CTRL_W   = 16,
   parameter int POS_10H  = 5,
   parameter int POS_10F  = 6,
   parameter int POS_TXH  = 7,
   parameter int POS_TXF  = 8,
   parameter int POS_T4   = 9,
   parameter int CTL_AN   = 12,
   parameter int CTL_SPD  = 13,
   parameter int CTL_DUP  = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CTRL_W-1:0] ctrl_i,
   input  logic [ABIL_W-1:0] local_adv_i,
   input  logic [ABIL_W-1:0] partner_abil_i,
   input  logic              an_done_i,
   output logic [3:0]        mode_sel_o,
   output logic              resolved_o,
   output logic              no_common_o
);
   import an_res_pkg::*;

   initial begin
      assert (CTL_AN < CTRL_W && CTL_SPD < CTRL_W && CTL_DUP < CTRL_W)
         else $fatal(1, "control bit position beyond word width");
      assert (POS_T4 < ABIL_W) else $fatal(1, "four-pair bit beyond word width");
      assert (NUM_MODES == 4) else $fatal(1, "mode select width mismatch");
   end

   logic an_en;
   assign an_en = ctrl_i[CTL_AN];

   logic [NUM_MODES-1:0] cand;
   logic [NUM_MODES-1:0] pick;
   logic                 pick_none;
   logic [NUM_MODES-1:0] forced_sel;

   an_ability_match #(
      .ABIL_W (ABIL_W),
      .POS_10H(POS_10H),
      .POS_10F(POS_10F),
      .POS_TXH(POS_TXH),
      .POS_TXF(POS_TXF)
   ) u_match (
      .local_i  (local_adv_i),
      .partner_i(partner_abil_i),
      .cand_o   (cand)
   );

   an_prio_pick #(.N(NUM_MODES)) u_pick (
      .req_i (cand),
      .pick_o(pick),
      .none_o(pick_none)
   );

   an_forced_decode u_force (
      .speed_i (ctrl_i[CTL_SPD]),
      .duplex_i(ctrl_i[CTL_DUP]),
      .sel_o   (forced_sel)
   );

   res_t res_q, res_d;
   logic an_en_q;

   always_comb begin
      res_d = res_q;
      if (!an_en) begin
         res_d = '{sel: forced_sel, valid: 1'b1, none: 1'b0};
      end else if (an_done_i) begin
         res_d.valid = 1'b1;
         res_d.none  = pick_none;
         res_d.sel   = pick_none ? SEL_DEFAULT : pick;
      end else if (!an_en_q) begin
         res_d = RES_IDLE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_q   <= RES_IDLE;
         an_en_q <= 1'b1;
      end else begin
         res_q   <= res_d;
         an_en_q <= an_en;
      end
   end

   assign mode_sel_o  = res_q.sel;
   assign resolved_o  = res_q.valid;
   assign no_common_o = res_q.none;

   logic unused_bits;
   assign unused_bits = ^{ctrl_i, local_adv_i, partner_abil_i};

   // ---------------- assertions ----------------
   assert_sel_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(mode_sel_o) == 1);

   assert_forced_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !an_en |=> (resolved_o && !no_common_o));

   assert_forced_fast_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!an_en && ctrl_i[CTL_SPD] && ctrl_i[CTL_DUP]) |=> (mode_sel_o == 4'b1000));

   assert_an_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (an_en && an_en_q && !an_done_i) |=>
         ($stable(mode_sel_o) && $stable(resolved_o) && $stable(no_common_o)));

   assert_none_default_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      no_common_o |-> (mode_sel_o == SEL_DEFAULT && resolved_o));

   assert_t4_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (an_en && an_done_i && local_adv_i[POS_T4] && partner_abil_i[POS_T4] && cand == '0)
         |=> no_common_o);

   assert_enter_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (an_en && !an_en_q && !an_done_i) |=> !resolved_o);

   assert_eligible_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (an_en && an_done_i && !(local_adv_i[POS_TXF] && partner_abil_i[POS_TXF]))
         |=> !mode_sel_o[3]);
endmodule

// File: tb/an_mode_resolver_tb.sv
module an_mode_resolver_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ctrl = 16'h1000;
   logic [15:0] adv = 16'h0000;
   logic [15:0] par = 16'h0000;
   logic        done = 1'b0;
   logic [3:0]  sel;
   logic        valid;
   logic        nc;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit armed  = 0;
   bit ended  = 0;
   string tag = "R9";

   // reference model state
   int m_sel   = 1;
   bit m_valid = 0;
   bit m_nc    = 0;
   bit m_anq   = 1;

   always #(CLK_PERIOD/2) clk = ~clk;

   an_mode_resolver dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .ctrl_i        (ctrl),
      .local_adv_i   (adv),
      .partner_abil_i(par),
      .an_done_i     (done),
      .mode_sel_o    (sel),
      .resolved_o    (valid),
      .no_common_o   (nc)
   );

   // ability bit position -> select value, in ranking order (four-pair included, then skipped)
   function automatic void model_negotiate(input logic [15:0] a, input logic [15:0] p);
      int rank_pos[$] = '{8, 9, 7, 6, 5};
      int rank_sel[$] = '{8, 0, 4, 2, 1};
      m_valid = 1;
      m_nc = 1;
      m_sel = 1;
      foreach (rank_pos[k]) begin
         if (a[rank_pos[k]] && p[rank_pos[k]] && rank_sel[k] != 0) begin
            m_sel = rank_sel[k];
            m_nc = 0;
            break;
         end
      end
   endfunction

   always @(posedge clk) begin
      cyc++;
      armed = 1;
      if (!rst_n) begin
         m_sel = 1; m_valid = 0; m_nc = 0; m_anq = 1;
      end else begin
         if (!ctrl[12]) begin
            m_sel = ctrl[13] ? (ctrl[8] ? 8 : 4) : (ctrl[8] ? 2 : 1);
            m_valid = 1;
            m_nc = 0;
         end else if (done) begin
            model_negotiate(adv, par);
         end else if (!m_anq) begin
            m_sel = 1; m_valid = 0; m_nc = 0;
         end
         m_anq = ctrl[12];
      end
      if (cyc > WATCHDOG && !ended) begin
         ended = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // compare on every falling edge
   always @(negedge clk) begin
      if (armed && !ended) begin
         checks++;
         if (sel !== 4'(m_sel) || valid !== m_valid || nc !== m_nc) begin
            fails++;
            $display("FAIL %s: sel=%b valid=%b nc=%b expected sel=%b valid=%b nc=%b",
                     tag, sel, valid, nc, 4'(m_sel), m_valid, m_nc);
         end
         checks++;
         if ($countones(sel) != 1) begin
            fails++;
            $display("FAIL R10: sel=%b expected one-hot", sel);
         end
      end
   end

   task automatic drive(input logic [15:0] c, input logic [15:0] a,
                        input logic [15:0] p, input logic d);
      @(negedge clk);
      ctrl = c; adv = a; par = p; done = d;
   endtask

   task automatic strobe(input logic [15:0] a, input logic [15:0] p);
      drive(16'h1000, a, p, 1'b1);
      drive(16'h1000, a, p, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state held; R4 partner wiggle without strobe
      tag = "R4";
      for (int i = 0; i < 5; i++) drive(16'h1000, 16'h03E0, 16'(i * 16'h0123), 1'b0);
      // R2 ranking, R8 one-cycle latency
      tag = "R2";
      strobe(16'h03E0, 16'h03E0);
      strobe(16'h03E0, 16'h00E0);
      strobe(16'h03E0, 16'h0060);
      strobe(16'h03E0, 16'h0020);
      tag = "R8";
      drive(16'h1000, 16'h03E0, 16'h0100, 1'b1);
      drive(16'h1000, 16'h03E0, 16'h0040, 1'b1);
      drive(16'h1000, 16'h03E0, 16'h0040, 1'b0);
      // R1 eligibility needs both sides
      tag = "R1";
      strobe(16'h00A0, 16'h0140);
      strobe(16'h01E0, 16'h0140);
      strobe(16'h0040, 16'h01A0);
      // R3 four-pair never chosen
      tag = "R3";
      strobe(16'h03E0, 16'h0200);
      strobe(16'h03E0, 16'h0220);
      strobe(16'h0380, 16'h0280);
      // R7 no common
      tag = "R7";
      strobe(16'h0000, 16'h03E0);
      // R4 results held while words change
      tag = "R4";
      strobe(16'h03E0, 16'h0080);
      for (int i = 0; i < 4; i++) drive(16'h1000, 16'h03E0, 16'h0100, 1'b0);
      // R6 speed/duplex ignored during negotiation
      tag = "R6";
      drive(16'h3100, 16'h03E0, 16'h0100, 1'b0);
      drive(16'h1100, 16'h03E0, 16'h0100, 1'b0);
      drive(16'h3000, 16'h03E0, 16'h0100, 1'b0);
      // R5 forced modes
      tag = "R5";
      drive(16'h0000, 16'h0000, 16'h0000, 1'b0);
      drive(16'h0100, 16'h0000, 16'h0000, 1'b1);
      drive(16'h2000, 16'h03E0, 16'h03E0, 1'b0);
      drive(16'h2100, 16'h0000, 16'h0000, 1'b0);
      // R9 re-entering negotiation
      tag = "R9";
      drive(16'h1000, 16'h03E0, 16'h03E0, 1'b0);
      drive(16'h1000, 16'h03E0, 16'h03E0, 1'b0);
      drive(16'h0000, 16'h03E0, 16'h03E0, 1'b0);
      drive(16'h1000, 16'h03E0, 16'h0060, 1'b1);
      drive(16'h1000, 16'h03E0, 16'h0060, 1'b0);
      // mixed stimulus
      tag = "R2";
      for (int i = 0; i < 400; i++) begin
         logic [15:0] c;
         c = 16'($urandom);
         if ($urandom_range(3) != 0) c[12] = 1'b1;
         else c[12] = 1'b0;
         drive(c, 16'($urandom), 16'($urandom), 1'($urandom_range(3) == 0));
      end
      drive(16'h1000, 16'h0000, 16'h0000, 1'b0);
      @(negedge clk);
      @(posedge clk);
      if (!ended) begin
         ended = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule